// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events from two groups, a bus-interface group and a DMA group, into status words the host can see. Each group has one event input bit per status bit, a mask bit and a fatal bit per status bit. A two-bit summary shows which group has a pending interrupt, and an active-low request line signals the host. Reading a group's status (one strobe cycle) clears that group's visible word and its summary bit.

While either summary bit is set, new events do not touch the visible words. They accumulate in a hidden second level of the same shape. Once the host has cleared every pending group, the request line is held high for a fixed gap. The hidden contents then move into the visible words in one step, and the request is raised again. A masked nonfatal event is still recorded in the visible word. It raises neither the summary nor the request, so it never starts stacking. A masked fatal event raises its summary bit for pollers but not the request.

All pins are plain control and status levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Events are single-cycle pulses sampled on each rising clock edge.

Top module: `stk_irq_ctrl`

## Requirements
- R1: An event with its mask bit clear, arriving while nothing is stacking, sets its bit in the visible status word one clock edge later. It sets its group's summary bit (pend[0] bus group, pend[1] DMA group) one edge after that, and irq_n goes low at that same edge.
- R2: An event whose mask bit is set and fatal bit is clear sets its visible status bit. It leaves pend at 0 and irq_n high.
- R3: An event whose mask bit and fatal bit are both set sets its visible status bit and its summary bit, but irq_n stays high.
- R4: While either summary bit is set, or the gap is running, new events go into the hidden level and the visible status words do not change.
- R5: Events stacked over several cycles OR together in the hidden level, and all of them appear together when it is promoted.
- R6: A read strobe (rd_bus or rd_dma high for one cycle) zeroes that group's visible status word and summary bit at the next edge. While the other group is still pending, nothing is promoted.
- R7: When a read leaves both summary bits clear and the hidden level is not empty, irq_n stays high for GAP_CYC+1 sampled cycles after the read edge. The hidden bits become visible GAP_CYC edges after the read edge, and irq_n goes low again one edge later.
- R8: When a read leaves both summary bits clear and the hidden level is empty, the block goes idle with irq_n high and does not raise the request again by itself.
- R9: Events that arrive before the summary bit has been set land in the visible words without stacking. This covers events in the same cycle from both groups, and an event in the cycle right after the first event.
- R10: Setting a mask bit after irq_n has gone low does not raise irq_n. Only reads end the request.
- R11: A masked nonfatal bit left in a visible word stays set when a later unmasked event in the same group is reported, and that later event is not stacked.
- R12: After reset, both status words, the summary and the hidden level are zero and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_bus | input | NA | Bus-group event pulses, one per status bit |
| evt_dma | input | NB | DMA-group event pulses, one per status bit |
| mask_bus | input | NA | Bus-group per-bit request mask (1 = masked) |
| mask_dma | input | NB | DMA-group per-bit request mask (1 = masked) |
| fatal_bus | input | NA | Bus-group per-bit fatal class (1 = fatal) |
| fatal_dma | input | NB | DMA-group per-bit fatal class (1 = fatal) |
| rd_bus | input | 1 | Read-to-clear strobe for the bus-group status |
| rd_dma | input | 1 | Read-to-clear strobe for the DMA-group status |
| stat_bus | output | NA | Visible bus-group status word |
| stat_dma | output | NB | Visible DMA-group status word |
| pend | output | 2 | Summary: bit 0 bus group, bit 1 DMA group |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A status bit is due one edge after its event, and the summary bit and request fall one edge after that. A clear takes effect one edge after the strobe, and promotion lands GAP_CYC edges after the clearing edge. The request returns one edge after promotion. The bench drives inputs at the falling edge, advances exactly one rising edge per table row, and compares at the next falling edge. Each expected value in a row is therefore written for the edge where it is due, counting the status register, the summary register and the gap counter.

// File: rtl/stk_irq_pkg.sv
package stk_irq_pkg;
  // Cycles the request line is forced high before promotion.
  localparam int unsigned GAP_DEFAULT = 3;

  // Index of each group inside the summary vector.
  typedef enum logic {
    GRP_BUS = 1'b0,
    GRP_DMA = 1'b1
  } grp_e;

  localparam int unsigned NUM_GRP = 2;
endpackage

// File: rtl/stk_irq_group.sv
// One interrupt group: visible word, hidden word, summary and request flags.
module stk_irq_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] fatal,
  input  logic         rd,
  input  logic         stack_en,
  input  logic         promote,
  output logic [W-1:0] stat,
  output logic         pend,
  output logic         req,
  output logic         quiet_nxt,
  output logic         hidden_nxt
);
  logic [W-1:0] shadow_q;
  logic         qual_q, rq_q;

  logic [W-1:0] land, park, lift, fresh;
  logic [W-1:0] stat_d, shadow_d;
  logic         qual_d, rq_d, pend_d, req_d;

  always_comb begin
    land     = stack_en ? '0 : evt;
    park     = stack_en ? evt : '0;
    lift     = promote ? shadow_q : '0;
    fresh    = land | lift;
    stat_d   = (rd ? '0 : stat) | fresh;
    shadow_d = (promote ? '0 : shadow_q) | park;
    // Summary trigger: unmasked or fatal. Request trigger: unmasked only.
    qual_d   = |(fresh & (~mask | fatal));
    rq_d     = |(fresh & ~mask);
    pend_d   = rd ? 1'b0 : (pend | qual_q);
    req_d    = rd ? 1'b0 : (req | rq_q);
    quiet_nxt  = !pend_d && !qual_d;
    hidden_nxt = |shadow_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= '0;
      shadow_q <= '0;
      qual_q   <= 1'b0;
      rq_q     <= 1'b0;
      pend     <= 1'b0;
      req      <= 1'b0;
    end else begin
      stat     <= stat_d;
      shadow_q <= shadow_d;
      qual_q   <= qual_d;
      rq_q     <= rq_d;
      pend     <= pend_d;
      req      <= req_d;
    end
  end
endmodule

// File: rtl/stk_irq_gap.sv
// Post-clear gap timer: holds the request off, then fires a promote pulse.
module stk_irq_gap #(
  parameter int unsigned GAP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic promote,
  output logic hold
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt;

  assign active  = (cnt != '0);
  assign promote = (cnt == CW'(1));
  assign hold    = (cnt > CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start && !active)
      cnt <= CW'(GAP_CYC);
    else if (active)
      cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/stk_irq_ctrl.sv
module stk_irq_ctrl
  import stk_irq_pkg::*;
#(
  parameter int unsigned NA      = 16,
  parameter int unsigned NB      = 8,
  parameter int unsigned GAP_CYC = GAP_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] evt_bus,
  input  logic [NB-1:0] evt_dma,
  input  logic [NA-1:0] mask_bus,
  input  logic [NB-1:0] mask_dma,
  input  logic [NA-1:0] fatal_bus,
  input  logic [NB-1:0] fatal_dma,
  input  logic          rd_bus,
  input  logic          rd_dma,
  output logic [NA-1:0] stat_bus,
  output logic [NB-1:0] stat_dma,
  output logic [1:0]    pend,
  output logic          irq_n
);
  logic [NUM_GRP-1:0] req, quiet, hidden;
  logic gap_active, gap_promote, gap_hold, stack_en, gap_start;

  // Stacking is on while any summary bit is set or the gap is still counting.
  assign stack_en  = (|pend) || gap_hold;
  assign gap_start = (&quiet) && (|hidden);

  stk_irq_group #(.W(NA)) u_bus (
    .clk(clk), .rst_n(rst_n), .evt(evt_bus), .mask(mask_bus),
    .fatal(fatal_bus), .rd(rd_bus), .stack_en(stack_en),
    .promote(gap_promote), .stat(stat_bus), .pend(pend[GRP_BUS]),
    .req(req[GRP_BUS]), .quiet_nxt(quiet[GRP_BUS]),
    .hidden_nxt(hidden[GRP_BUS])
  );

  stk_irq_group #(.W(NB)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(evt_dma), .mask(mask_dma),
    .fatal(fatal_dma), .rd(rd_dma), .stack_en(stack_en),
    .promote(gap_promote), .stat(stat_dma), .pend(pend[GRP_DMA]),
    .req(req[GRP_DMA]), .quiet_nxt(quiet[GRP_DMA]),
    .hidden_nxt(hidden[GRP_DMA])
  );

  stk_irq_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start),
    .active(gap_active), .promote(gap_promote), .hold(gap_hold)
  );

  assign irq_n = !((|req) && !gap_active);
endmodule

// File: rtl/stk_irq_ctrl_chk.sv
module stk_irq_ctrl_chk #(
  parameter int unsigned NA = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NA-1:0] stat_bus,
  input logic [1:0]    pend,
  input logic          irq_n,
  input logic          rd_bus,
  input logic          rd_dma,
  input logic          gap_active
);
  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |=> (irq_n && pend == 2'b00));

  assert_pend_after_stat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(stat_bus != '0));

  assert_visible_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !rd_bus) |=> stat_bus == $past(stat_bus));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bus && pend[0]) |=> (stat_bus == '0 && !pend[0]));

  assert_gap_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap_active) |-> irq_n ##1 irq_n ##1 irq_n);

  assert_no_self_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_bus && !rd_dma) |=> !irq_n);
endmodule

bind stk_irq_ctrl stk_irq_ctrl_chk #(.NA(NA)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_bus(stat_bus), .pend(pend),
  .irq_n(irq_n), .rd_bus(rd_bus), .rd_dma(rd_dma), .gap_active(gap_active)
);

// File: tb/stk_irq_ctrl_tb.sv
module stk_irq_ctrl_tb;
  localparam int unsigned NA = 16;
  localparam int unsigned NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] evt_bus = '0, mask_bus = '0, fatal_bus = '0, stat_bus;
  logic [NB-1:0] evt_dma = '0, mask_dma = '0, fatal_dma = '0, stat_dma;
  logic rd_bus = 1'b0, rd_dma = 1'b0;
  logic [1:0] pend;
  logic irq_n;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stk_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .evt_dma(evt_dma),
    .mask_bus(mask_bus), .mask_dma(mask_dma), .fatal_bus(fatal_bus),
    .fatal_dma(fatal_dma), .rd_bus(rd_bus), .rd_dma(rd_dma),
    .stat_bus(stat_bus), .stat_dma(stat_dma), .pend(pend), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [15:0] ea;
    logic [7:0]  eb;
    logic        ra;
    logic        rb;
    logic [15:0] xa;
    logic [7:0]  xb;
    logic [1:0]  xp;
    logic        xi;
  } vec_t;

  // Rows: inputs for one edge, then outputs expected after that edge.
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 8'h00, 1'b0, 1'b0, 16'h0001, 8'h00, 2'b00, 1'b1}, // R1 status
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0001, 8'h00, 2'b01, 1'b0}, // R1 summary
    '{16'h0002, 8'h00, 1'b0, 1'b0, 16'h0001, 8'h00, 2'b01, 1'b0}, // R4 stacked
    '{16'h0004, 8'h00, 1'b0, 1'b0, 16'h0001, 8'h00, 2'b01, 1'b0}, // R5 stacked
    '{16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R6/R7 read
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R7 gap
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R7 gap
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0006, 8'h00, 2'b00, 1'b1}, // R5/R7 promote
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0006, 8'h00, 2'b01, 1'b0}, // R7 reassert
    '{16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R8 read
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R8 idle
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R8 idle
    '{16'h0010, 8'h01, 1'b0, 1'b0, 16'h0010, 8'h01, 2'b00, 1'b1}, // R9 both
    '{16'h0020, 8'h00, 1'b0, 1'b0, 16'h0030, 8'h01, 2'b11, 1'b0}, // R9 window
    '{16'h0040, 8'h00, 1'b0, 1'b0, 16'h0030, 8'h01, 2'b11, 1'b0}, // R4 stacked
    '{16'h0000, 8'h00, 1'b0, 1'b1, 16'h0030, 8'h00, 2'b01, 1'b0}, // R6 dma read
    '{16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R7 read
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R7 gap
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}, // R7 gap
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0040, 8'h00, 2'b00, 1'b1}, // R7 promote
    '{16'h0000, 8'h00, 1'b0, 1'b0, 16'h0040, 8'h00, 2'b01, 1'b0}, // R7 reassert
    '{16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000, 8'h00, 2'b00, 1'b1}  // R6 final
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    evt_bus = '0; evt_dma = '0; rd_bus = 1'b0; rd_dma = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [15:0] xa,
                            input logic [7:0] xb, input logic [1:0] xp,
                            input logic xi);
    chk({tag, " stat_bus"}, 32'(stat_bus), 32'(xa));
    chk({tag, " stat_dma"}, 32'(stat_dma), 32'(xb));
    chk({tag, " pend"}, 32'(pend), 32'(xp));
    chk({tag, " irq_n"}, 32'(irq_n), 32'(xi));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step();
    expect_all("R12 reset", 16'h0, 8'h0, 2'b00, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      evt_bus = VEC[i].ea; evt_dma = VEC[i].eb;
      rd_bus = VEC[i].ra; rd_dma = VEC[i].rb;
      step();
      clear_inputs();
      expect_all($sformatf("table row %0d", i), VEC[i].xa, VEC[i].xb,
                 VEC[i].xp, VEC[i].xi);
    end

    // R2 and R11: masked nonfatal bit posts, no summary, then later event unstacked.
    mask_bus = 16'h0001;
    evt_bus = 16'h0001; step(); clear_inputs();
    expect_all("R2 post", 16'h0001, 8'h0, 2'b00, 1'b1);
    step();
    expect_all("R2 quiet", 16'h0001, 8'h0, 2'b00, 1'b1);
    evt_bus = 16'h0100; step(); clear_inputs();
    expect_all("R11 lands", 16'h0101, 8'h0, 2'b00, 1'b1);
    step();
    expect_all("R11 raised", 16'h0101, 8'h0, 2'b01, 1'b0);
    rd_bus = 1'b1; step(); clear_inputs();
    expect_all("R11 cleared", 16'h0, 8'h0, 2'b00, 1'b1);
    mask_bus = '0;

    // R3: masked fatal DMA bit raises summary but not the request.
    mask_dma = 8'h01; fatal_dma = 8'h01;
    evt_dma = 8'h01; step(); clear_inputs();
    step();
    expect_all("R3 fatal", 16'h0, 8'h01, 2'b10, 1'b1);
    rd_dma = 1'b1; step(); clear_inputs();
    expect_all("R3 cleared", 16'h0, 8'h0, 2'b00, 1'b1);
    mask_dma = '0; fatal_dma = '0;

    // R10: masking after the request is up leaves it up.
    evt_bus = 16'h0008; step(); clear_inputs();
    step();
    expect_all("R10 up", 16'h0008, 8'h0, 2'b01, 1'b0);
    mask_bus = 16'hFFFF;
    step();
    step();
    expect_all("R10 masked late", 16'h0008, 8'h0, 2'b01, 1'b0);
    rd_bus = 1'b1; step(); clear_inputs();
    expect_all("R10 released", 16'h0, 8'h0, 2'b00, 1'b1);
    mask_bus = '0;

    // R12: reset in the middle of a pending state returns everything to idle.
    evt_dma = 8'h80; step(); clear_inputs();
    step();
    rst_n = 1'b0; step();
    expect_all("R12 mid reset", 16'h0, 8'h0, 2'b00, 1'b1);
    rst_n = 1'b1; step();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule